// File: doc/BRIEF.md
# Leveled 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and picks one source to present to the processor. Each source has an 8-bit priority byte that also serves as its enable: a zero byte switches the source off. A source takes part in arbitration only when it is requested, enabled and not masked. The controller drives the winner's priority byte and vector number to the processor on two registered outputs.

Software reaches the controller through a 256-byte window on a simple 32-bit bus. The bus has an address, a write strobe and write data, and read data is decoded combinationally from the address. The window holds a pending view, a 64-bit mask split across two words, a force register that always reads zero in this version, one priority byte per source, and an acknowledge word that returns the current vector. When no source qualifies, the processor sees level 0 and the spurious vector.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A source is eligible when (its pending bit OR its force bit) is set, its priority byte is nonzero and its mask bit is 0. A masked, disabled or idle source never wins.
- R2: Among eligible sources, the one with the largest priority byte wins. Bytes compare as unsigned values, so 0x80 beats 0x7F.
- R3: When two or more eligible sources share the largest byte, the source with the highest index wins.
- R4: While a source wins, irq_vector equals its index plus 64 (source 0 gives 64, source 63 gives 127), and irq_level carries its full 8-bit priority byte.
- R5: When no source is eligible, irq_vector is 24 and irq_level is 0.
- R6: A write to offset 0x40+n stores bus_wdata[7:0] as the priority byte of source n. A nonzero byte enables the source and zero disables it. A read of offset 0x40+n returns the byte in bits 7:0.
- R7: The mask register sits at 0x08 for sources 63..32 (bit k covers source 32+k) and at 0x0C for sources 31..0 (bit k covers source k). A 1 masks the source. Both words can be written and read back.
- R8: Offset 0x00 reads irq_req[63:32] and offset 0x04 reads irq_req[31:0], each as sampled one clock earlier. Writes to these two offsets have no effect.
- R9: The force words at 0x10 (upper) and 0x14 (lower) always read 0. Writes to them change neither the read value nor arbitration.
- R10: A read of offset 0xE0 returns the current irq_vector in bits 7:0, with the upper bits zero.
- R11: After reset the mask reads all ones, and the pending view, the force words and every priority byte read zero. irq_vector is 24 and irq_level is 0.
- R12: Only the exact offsets listed above and the byte window 0x40..0x7F are decoded. Other offsets read 0, and writes to them change no state.
- R13: The outputs are registered. A change on irq_req reaches irq_vector and irq_level at the second rising edge after it. A register write reaches them at the first rising edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data decoded from bus_addr |
| irq_level | output | 8 | Priority byte of the winning source, 0 when idle |
| irq_vector | output | 8 | Vector of the winning source, 24 when idle |

## Verification
On every cycle the assertions check the following:
- the arbiter's pick is an eligible source;
- no eligible source has a larger byte than the pick;
- no eligible source with an equal byte has a larger index;
- each enable bit agrees with its stored byte;
- the mask holds still when no mask word is written;
- the idle level and the spurious vector always appear together.

Only the bench's scenarios can show the following:
- the bus decode, meaning which offsets read as what and which writes are ignored;
- the exact vector arithmetic;
- the reset contents;
- the one-cycle and two-cycle output latency.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned OFS_W = 8;

  localparam logic [OFS_W-1:0] OFS_PEND_HI = 8'h00;
  localparam logic [OFS_W-1:0] OFS_PEND_LO = 8'h04;
  localparam logic [OFS_W-1:0] OFS_MASK_HI = 8'h08;
  localparam logic [OFS_W-1:0] OFS_MASK_LO = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_FRC_HI  = 8'h10;
  localparam logic [OFS_W-1:0] OFS_FRC_LO  = 8'h14;
  localparam logic [OFS_W-1:0] OFS_SWACK   = 8'hE0;

  // Priority byte window: the upper address bits select it, the low bits index the source.
  function automatic logic in_prio_window(input logic [OFS_W-1:0] ofs, input int unsigned idx_w);
    return (ofs >> idx_w) == 1;
  endfunction
endpackage

// File: rtl/lic_regs.sv
module lic_regs #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned LVLW = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned VECW = 8,
  localparam int unsigned IW   = $clog2(NSRC),
  localparam int unsigned HALF = NSRC / 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      irq_req,
  input  logic [7:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic [VECW-1:0]      cur_vec,
  output logic [DW-1:0]        bus_rdata,
  output logic [NSRC-1:0]      pend,
  output logic [NSRC-1:0]      mask,
  output logic [NSRC-1:0]      frc,
  output logic [NSRC-1:0]      enab,
  output logic [NSRC*LVLW-1:0] lvl_flat
);
  import lic_pkg::*;

  logic [LVLW-1:0] prio_q [NSRC];
  logic            in_win;
  logic            wr_mask_hi, wr_mask_lo;

  assign in_win     = in_prio_window(bus_addr, IW);
  assign wr_mask_hi = bus_wr && (bus_addr == OFS_MASK_HI);
  assign wr_mask_lo = bus_wr && (bus_addr == OFS_MASK_LO);

  // Force register: present in the map, fixed at zero in this version.
  assign frc = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '1;
    end else begin
      pend <= irq_req;
      if (wr_mask_hi) mask[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
      if (wr_mask_lo) mask[HALF-1:0]    <= bus_wdata[HALF-1:0];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic wr_this;
    assign wr_this = bus_wr && in_win && (bus_addr[IW-1:0] == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prio_q[i] <= '0;
        enab[i]   <= 1'b0;
      end else if (wr_this) begin
        prio_q[i] <= bus_wdata[LVLW-1:0];
        enab[i]   <= (bus_wdata[LVLW-1:0] != '0);
      end
    end

    assign lvl_flat[i*LVLW +: LVLW] = prio_q[i];

    p_enab_tracks_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      enab[i] == (prio_q[i] != '0));
  end

  always_comb begin
    bus_rdata = '0;
    if (in_win) begin
      bus_rdata = DW'(prio_q[bus_addr[IW-1:0]]);
    end else begin
      case (bus_addr)
        OFS_PEND_HI: bus_rdata = DW'(pend[NSRC-1:HALF]);
        OFS_PEND_LO: bus_rdata = DW'(pend[HALF-1:0]);
        OFS_MASK_HI: bus_rdata = DW'(mask[NSRC-1:HALF]);
        OFS_MASK_LO: bus_rdata = DW'(mask[HALF-1:0]);
        OFS_FRC_HI:  bus_rdata = DW'(frc[NSRC-1:HALF]);
        OFS_FRC_LO:  bus_rdata = DW'(frc[HALF-1:0]);
        OFS_SWACK:   bus_rdata = DW'(cur_vec);
        default:     bus_rdata = '0;
      endcase
    end
  end

  p_mask_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_mask_hi || wr_mask_lo) |=> $stable(mask));
endmodule

// File: rtl/lic_arb.sv
module lic_arb #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned LVLW = 8,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]      active,
  input  logic [NSRC*LVLW-1:0] lvl_flat,
  output logic                 win_vld,
  output logic [IW-1:0]        win_idx,
  output logic [LVLW-1:0]      win_lvl
);
  // Ascending scan; ">=" hands equal levels to the later (higher) index.
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (lvl_flat[i*LVLW +: LVLW] >= win_lvl)) begin
        win_vld = 1'b1;
        win_idx = IW'(i);
        win_lvl = lvl_flat[i*LVLW +: LVLW];
      end
    end
  end
endmodule

// File: rtl/lic_vecgen.sv
module lic_vecgen #(
  parameter int unsigned IW       = 6,
  parameter int unsigned LVLW     = 8,
  parameter int unsigned VECW     = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_SPUR = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_vld,
  input  logic [IW-1:0]   win_idx,
  input  logic [LVLW-1:0] win_lvl,
  output logic [LVLW-1:0] irq_level,
  output logic [VECW-1:0] irq_vector
);
  function automatic logic [VECW-1:0] vec_of(input logic vld, input logic [IW-1:0] idx);
    return vld ? (VECW'(VEC_BASE) + VECW'(idx)) : VECW'(VEC_SPUR);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_level  <= '0;
      irq_vector <= VECW'(VEC_SPUR);
    end else begin
      irq_level  <= win_vld ? win_lvl : '0;
      irq_vector <= vec_of(win_vld, win_idx);
    end
  end

  p_idle_gives_spur_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |=> (irq_vector == VECW'(VEC_SPUR)) && (irq_level == '0));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int unsigned NSRC     = 64,
  parameter int unsigned LVLW     = 8,
  parameter int unsigned DW       = 32,
  parameter int unsigned VECW     = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_SPUR = 24,
  localparam int unsigned IW      = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [LVLW-1:0]  irq_level,
  output logic [VECW-1:0]  irq_vector
);
  logic [NSRC-1:0]      pend, mask, frc, enab, active;
  logic [NSRC*LVLW-1:0] lvl_flat;
  logic                 win_vld;
  logic [IW-1:0]        win_idx;
  logic [LVLW-1:0]      win_lvl;

  lic_regs #(.NSRC(NSRC), .LVLW(LVLW), .DW(DW), .VECW(VECW)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .cur_vec(irq_vector), .bus_rdata(bus_rdata),
    .pend(pend), .mask(mask), .frc(frc), .enab(enab), .lvl_flat(lvl_flat)
  );

  // Eligibility event brought out for the checks below.
  assign active = (pend | frc) & enab & ~mask;

  lic_arb #(.NSRC(NSRC), .LVLW(LVLW)) u_arb (
    .active(active), .lvl_flat(lvl_flat),
    .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  lic_vecgen #(.IW(IW), .LVLW(LVLW), .VECW(VECW),
               .VEC_BASE(VEC_BASE), .VEC_SPUR(VEC_SPUR)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .win_vld(win_vld), .win_idx(win_idx), .win_lvl(win_lvl),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  p_pick_is_eligible_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> active[win_idx]);

  p_any_eligible_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active != '0) |-> win_vld);

  p_spur_pairs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vector == VECW'(VEC_SPUR)) == (irq_level == '0));

  p_vec_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vector == VECW'(VEC_SPUR)) ||
    ((irq_vector >= VECW'(VEC_BASE)) && (irq_vector < VECW'(VEC_BASE + NSRC))));

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    p_none_higher_r2: assert property (@(posedge clk) disable iff (!rst_n)
      active[i] |-> (lvl_flat[i*LVLW +: LVLW] <= win_lvl));
    p_tie_to_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active[i] && (lvl_flat[i*LVLW +: LVLW] == win_lvl)) |-> (win_idx >= IW'(i)));
  end
endmodule

// File: tb/sim_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module sim_lvl_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_req = '0;
  logic [7:0]  bus_addr = 8'hFC;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_level;
  logic [7:0]  irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lvl_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  function automatic logic [7:0] exp_vec(input int idx);
    return (idx < 0) ? 8'd24 : 8'(idx + 64);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_req = '0; bus_wr = 1'b0; bus_addr = 8'hFC;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 8'hFC;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_out(input string req, input int idx, input logic [7:0] lvl);
    chk({req, " vector"}, 32'(irq_vector), 32'(exp_vec(idx)));
    chk({req, " level"},  32'(irq_level),  32'(lvl));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk_out("R11 R5", -1, 8'd0);
    rd(8'h08, d); chk("R11 mask hi", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R11 mask lo", d, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R11 pend hi", d, 0);
    rd(8'h04, d); chk("R11 pend lo", d, 0);
    rd(8'h14, d); chk("R11 force lo", d, 0);
    rd(8'h45, d); chk("R11 byte 5", d, 0);
    rd(8'hE0, d); chk("R10 swack idle", d, 32'd24);
  endtask

  task automatic t_mask_enable();
    logic [31:0] d;
    do_reset();
    wr(8'h45, 32'h3);
    irq_req[5] = 1'b1;
    settle();
    chk_out("R1 masked", -1, 8'd0);
    wr(8'h0C, ~(32'h1 << 5));
    @(negedge clk);
    chk_out("R1 unmasked", 5, 8'd3);
    rd(8'h0C, d); chk("R7 mask lo readback", d, 32'hFFFF_FFDF);
    wr(8'h45, 32'h0);
    @(negedge clk);
    chk_out("R6 zero byte disables", -1, 8'd0);
    rd(8'h45, d); chk("R6 byte readback", d, 0);
  endtask

  task automatic t_priority();
    do_reset();
    wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h43, 32'h2); wr(8'h68, 32'h7); wr(8'h4A, 32'h80); wr(8'h4B, 32'h7F);
    irq_req[3] = 1; irq_req[40] = 1; irq_req[10] = 1; irq_req[11] = 1;
    settle();
    chk_out("R2 unsigned 0x80 wins", 10, 8'h80);
    irq_req[10] = 0;
    settle();
    chk_out("R2 next highest", 11, 8'h7F);
  endtask

  task automatic t_tie();
    do_reset();
    wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h4A, 32'h6); wr(8'h54, 32'h6); wr(8'h72, 32'h6);
    irq_req[10] = 1; irq_req[20] = 1; irq_req[50] = 1;
    settle();
    chk_out("R3 tie highest index", 50, 8'h6);
    irq_req = '0;
    wr(8'h40, 32'h1); wr(8'h7F, 32'h1);
    irq_req[0] = 1; irq_req[63] = 1;
    settle();
    chk_out("R3 R4 tie top source", 63, 8'h1);
    irq_req[63] = 0;
    wr(8'h40, 32'hFF);
    settle();
    chk_out("R4 source zero full byte", 0, 8'hFF);
  endtask

  task automatic t_upper_mask();
    logic [31:0] d;
    do_reset();
    wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h68, 32'h9); wr(8'h42, 32'h4);
    irq_req[40] = 1; irq_req[2] = 1;
    settle();
    chk_out("R7 upper unmasked", 40, 8'h9);
    wr(8'h08, 32'h1 << 8);
    @(negedge clk);
    chk_out("R7 upper bit masks source 40", 2, 8'h4);
    rd(8'h08, d); chk("R7 mask hi readback", d, 32'h100);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    do_reset();
    irq_req[33] = 1; irq_req[1] = 1;
    settle();
    rd(8'h00, d); chk("R8 pend hi", d, 32'h2);
    rd(8'h04, d); chk("R8 pend lo", d, 32'h2);
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h00, 32'h0);
    rd(8'h04, d); chk("R8 pend lo write ignored", d, 32'h2);
    rd(8'h00, d); chk("R8 pend hi write ignored", d, 32'h2);
    irq_req = '0;
    settle();
    rd(8'h00, d); chk("R8 pend follows low input", d, 0);
  endtask

  task automatic t_force();
    logic [31:0] d;
    do_reset();
    wr(8'h08, 0); wr(8'h0C, 0);
    wr(8'h47, 32'h5);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R9 force hi reads 0", d, 0);
    rd(8'h14, d); chk("R9 force lo reads 0", d, 0);
    settle();
    chk_out("R9 force write no effect", -1, 8'd0);
  endtask

  task automatic t_swack();
    logic [31:0] d;
    do_reset();
    wr(8'h0C, 0);
    wr(8'h4C, 32'h3);
    irq_req[12] = 1;
    settle();
    rd(8'hE0, d); chk("R10 swack vector", d, 32'd76);
  endtask

  task automatic t_unlisted();
    logic [31:0] d;
    do_reset();
    wr(8'h4C, 32'h3);
    irq_req[12] = 1;
    wr(8'h0D, 32'h0); wr(8'h09, 32'h0); wr(8'h18, 32'h1234); wr(8'hE4, 32'h5);
    settle();
    rd(8'h0C, d); chk("R12 near-miss write keeps mask", d, 32'hFFFF_FFFF);
    chk_out("R12 no unmask via bad offset", -1, 8'd0);
    rd(8'h18, d); chk("R12 read 0x18", d, 0);
    rd(8'h80, d); chk("R12 read 0x80", d, 0);
    rd(8'hE4, d); chk("R12 read 0xE4", d, 0);
    rd(8'h3C, d); chk("R12 read 0x3C", d, 0);
  endtask

  task automatic t_timing();
    do_reset();
    wr(8'h0C, 0);
    wr(8'h48, 32'h2);
    @(negedge clk);
    irq_req[8] = 1;
    @(negedge clk);
    chk_out("R13 one edge after request", -1, 8'd0);
    @(negedge clk);
    chk_out("R13 two edges after request", 8, 8'h2);
    wr(8'h48, 32'h0);
    chk_out("R13 write edge only", 8, 8'h2);
    @(negedge clk);
    chk_out("R13 one edge after write", -1, 8'd0);
  endtask

  initial begin
    t_reset();
    t_mask_enable();
    t_priority();
    t_tie();
    t_upper_mask();
    t_pending();
    t_force();
    t_swack();
    t_unlisted();
    t_timing();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule